// File: doc/BRIEF.md
# Segmented Serial Delay Line with Bidirectional Segment Taps

This block is a static serial shift register of `NUM_SEG * SEG_LEN` stages. By default it has 64 stages in four runs of 16. Every stage moves on the rising clock edge. Each run ends in a tap. A tap can present the last stage of its run to an external bus, or it can accept a bit from that bus.

When the write control is low, the runs are joined end to end into one long delay line. All taps drive out the bit held at their boundary stage.

When the write control is high, every tap output is released. The bit on each of the first `NUM_SEG-1` taps then enters the first stage of the next run, while the serial input keeps feeding stage 1. Because all runs fill at the same time, the whole register loads in `SEG_LEN` clocks instead of `NUM_SEG * SEG_LEN`.

Each tap is presented as three separate signals: an output value, an output enable and an input value. Surrounding logic builds the three-state bus from these signals.

Top module: `segsr_tapped`

## Requirements
- R1: A synchronous active-high reset clears every stage, so all `tap_out` bits read 0 after a reset edge, whatever `wr_en` and the data inputs are.
- R2: On every rising edge, `ser_in` is captured into stage 1, whatever the value of `wr_en`.
- R3: With `wr_en` = 0, stage 16k+1 takes stage 16k for k = 1, 2, 3. A bit entered on `ser_in` first appears on `tap_out[k]` exactly 16(k+1) edges later, which makes 64 edges for `tap_out[3]`.
- R4: `tap_out[k]` always equals the content of stage 16(k+1), that is, the last stage of run k. Bit 0 is the tap after stage 16 and bit 3 is the tap after stage 64.
- R5: With `wr_en` = 1, a rising edge loads `tap_in[0]`, `tap_in[1]` and `tap_in[2]` into stages 17, 33 and 49, and the bit at a run's end does not pass into the next run. Sixteen such edges load all 64 stages.
- R6: All four bits of `tap_oe` are 1 while `wr_en` = 0 and all are 0 while `wr_en` = 1. This includes the tap after stage 64, which never takes input. The enables are never mixed.
- R7: Stage contents change only on a rising clock edge. Changes on `wr_en`, `tap_in` or `ser_in` between edges leave `tap_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all stages |
| ser_in | input | 1 | Serial data into stage 1 |
| wr_en | input | 1 | 0: chained delay line, taps drive; 1: taps receive, runs load in parallel |
| tap_in | input | NUM_SEG-1 (3) | Bus value at the taps after stages 16, 32, 48, entering stages 17, 33, 49 |
| tap_out | output | NUM_SEG (4) | Value of stages 16, 32, 48, 64 |
| tap_oe | output | NUM_SEG (4) | Output enable of each tap toward the shared bus |

## Verification
A single 1 pulsed into a cleared chain shows the exact delay to each tap. It tells a correct 16/32/48/64-edge latency apart from an off-by-one run length or a broken link between runs. Long random serial streams with the write control held low compare all four taps each cycle against a bit-level model, which exposes swapped or missing links. A random 64-bit word is then loaded in 16 write clocks and shifted back out serially. This separates a true parallel load from one that leaks boundary bits across runs or maps runs to the wrong taps. Random mixing of write control and tap inputs, together with input flips placed between clock edges, checks the enable rule and shows that the storage changes only at the edge.

// File: rtl/segsr_pkg.sv
package segsr_pkg;

   // Direction a segment tap currently plays on the shared bus
   typedef enum logic {
      TAP_DRIVE = 1'b0,
      TAP_SENSE = 1'b1
   } tap_dir_e;

   localparam int unsigned SEGSR_MIN_SEG_LEN = 2;
   localparam int unsigned SEGSR_MIN_NUM_SEG = 2;

   // Stage number (1-based) whose content a tap presents
   function automatic int unsigned tap_stage(input int unsigned seg_len,
                                             input int unsigned k);
      return seg_len * (k + 1);
   endfunction

endpackage

// File: rtl/segsr_segment.sv
module segsr_segment #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic head,
   output logic tail
);
   import segsr_pkg::*;

   generate
      if (LEN < SEGSR_MIN_SEG_LEN) begin : g_len_bad
         $error("segsr_segment: LEN must be at least 2");
      end
   endgenerate

   logic [LEN-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[LEN-2:0], din};
   end

   assign head = stg[0];
   assign tail = stg[LEN-1];

endmodule

// File: rtl/segsr_tapctl.sv
module segsr_tapctl #(
   parameter int unsigned NUM_SEG = 4
) (
   input  logic               wr_en,
   input  logic               ser_in,
   input  logic [NUM_SEG-2:0] tap_in,
   input  logic [NUM_SEG-1:0] seg_tail,
   output logic [NUM_SEG-1:0] seg_feed,
   output logic [NUM_SEG-1:0] tap_out,
   output logic [NUM_SEG-1:0] tap_oe
);
   import segsr_pkg::*;

   tap_dir_e dir;
   assign dir = tap_dir_e'(wr_en);

   assign seg_feed[0] = ser_in;

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_tap
      assign tap_out[k] = seg_tail[k];
      assign tap_oe[k]  = (dir == TAP_DRIVE);
      if (k > 0) begin : g_link
         assign seg_feed[k] = (dir == TAP_SENSE) ? tap_in[k-1] : seg_tail[k-1];
      end
   end

endmodule

// File: rtl/segsr_tapped.sv
module segsr_tapped #(
   parameter int unsigned SEG_LEN = 16,
   parameter int unsigned NUM_SEG = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ser_in,
   input  logic               wr_en,
   input  logic [NUM_SEG-2:0] tap_in,
   output logic [NUM_SEG-1:0] tap_out,
   output logic [NUM_SEG-1:0] tap_oe
);
   import segsr_pkg::*;

   localparam int unsigned TOTAL_STAGES = SEG_LEN * NUM_SEG;
   localparam int unsigned LAST_TAP     = tap_stage(SEG_LEN, NUM_SEG - 1);

   generate
      if (NUM_SEG < SEGSR_MIN_NUM_SEG) begin : g_nseg_bad
         $error("segsr_tapped: NUM_SEG must be at least 2");
      end
      if (LAST_TAP != TOTAL_STAGES) begin : g_geom_bad
         $error("segsr_tapped: tap geometry mismatch");
      end
   endgenerate

   logic [NUM_SEG-1:0] seg_feed;
   logic [NUM_SEG-1:0] seg_head;
   logic [NUM_SEG-1:0] seg_tail;

   segsr_tapctl #(.NUM_SEG(NUM_SEG)) u_tapctl (
      .wr_en    (wr_en),
      .ser_in   (ser_in),
      .tap_in   (tap_in),
      .seg_tail (seg_tail),
      .seg_feed (seg_feed),
      .tap_out  (tap_out),
      .tap_oe   (tap_oe)
   );

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      segsr_segment #(.LEN(SEG_LEN)) u_seg (
         .clk  (clk),
         .rst  (rst),
         .din  (seg_feed[k]),
         .head (seg_head[k]),
         .tail (seg_tail[k])
      );

      if (k == 0) begin : g_entry
         // R2
         ser_entry_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> seg_head[0] == $past(ser_in));
      end else begin : g_boundary
         // R3
         chain_link_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> seg_head[k] == $past(tap_out[k-1]));
         // R5
         tap_load_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> seg_head[k] == $past(tap_in[k-1]));
      end
   end

   // R6
   oe_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
      (tap_oe != '0) |-> ($countones(tap_oe) == NUM_SEG));

endmodule

// File: tb/tb_segsr_tapped.sv
module tb_segsr_tapped;
   localparam int SEG = 16;
   localparam int NS  = 4;
   localparam int TOT = SEG * NS;
   localparam time CLK_PERIOD = 20ns;

   logic          clk = 1'b0;
   logic          rst = 1'b0;
   logic          ser_in = 1'b0;
   logic          wr_en = 1'b0;
   logic [NS-2:0] tap_in = '0;
   logic [NS-1:0] tap_out;
   logic [NS-1:0] tap_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [TOT-1:0] mdl = '0;   // mdl[i] is stage i+1

   always #(CLK_PERIOD/2) clk = ~clk;

   segsr_tapped #(.SEG_LEN(SEG), .NUM_SEG(NS)) dut (
      .clk(clk), .rst(rst), .ser_in(ser_in), .wr_en(wr_en),
      .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
   );

   function automatic logic [TOT-1:0] next_state(input logic [TOT-1:0] cur,
                                                 input logic s, input logic we,
                                                 input logic [NS-2:0] ti);
      logic [TOT-1:0] nx;
      nx[0] = s;
      for (int i = 1; i < TOT; i++) begin
         if ((i % SEG) == 0 && we) nx[i] = ti[i/SEG - 1];
         else                      nx[i] = cur[i-1];
      end
      return nx;
   endfunction

   function automatic logic [NS-1:0] exp_taps(input logic [TOT-1:0] st);
      logic [NS-1:0] t;
      for (int k = 0; k < NS; k++) t[k] = st[SEG*(k+1) - 1];
      return t;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Entered at a negedge; leaves at the next negedge after one rising edge
   task automatic step(input logic s, input logic we, input logic [NS-2:0] ti,
                       input string req);
      ser_in = s; wr_en = we; tap_in = ti;
      @(posedge clk);
      mdl = next_state(mdl, s, we, ti);
      @(negedge clk);
      check(tap_out == exp_taps(mdl), req, 64'(tap_out), 64'(exp_taps(mdl)));
      check(tap_oe == {NS{~we}}, "R6", 64'(tap_oe), 64'({NS{~we}}));
   endtask

   task automatic do_reset(input logic we);
      rst = 1'b1; wr_en = we; ser_in = 1'b1; tap_in = '1;
      @(posedge clk);
      mdl = '0;
      @(negedge clk);
      rst = 1'b0;
      check(tap_out == '0, "R1", 64'(tap_out), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int first_seen [NS];
      logic [TOT-1:0] word;
      void'($urandom(32'h5E65_17A0));

      @(negedge clk);
      do_reset(1'b0);
      check(tap_oe == '1, "R6", 64'(tap_oe), 64'hF);

      // R3: single pulse latency to each tap
      for (int k = 0; k < NS; k++) first_seen[k] = -1;
      for (int n = 1; n <= TOT + 2; n++) begin
         step(n == 1, 1'b0, '0, "R3");
         for (int k = 0; k < NS; k++)
            if (tap_out[k] && first_seen[k] < 0) first_seen[k] = n;
      end
      for (int k = 0; k < NS; k++)
         check(first_seen[k] == SEG*(k+1), "R3", 64'(first_seen[k]), 64'(SEG*(k+1)));

      // R2 R4: random serial stream through the chain
      for (int n = 0; n < 160; n++)
         step(1'($urandom), 1'b0, 3'($urandom), "R4");

      // R1: reset with write enabled and busy inputs
      do_reset(1'b1);

      // R5: 16-clock parallel load, then serial readback
      word = {$urandom, $urandom};
      for (int c = 0; c < SEG; c++)
         step(word[SEG-1-c], 1'b1,
              {word[3*SEG+SEG-1-c], word[2*SEG+SEG-1-c], word[SEG+SEG-1-c]}, "R5");
      check(tap_out == {word[63], word[47], word[31], word[15]}, "R5",
            64'(tap_out), 64'({word[63], word[47], word[31], word[15]}));
      for (int m = 1; m < TOT; m++) begin
         step(1'b0, 1'b0, '0, "R3");
         check(tap_out[NS-1] == word[TOT-1-m], "R5", 64'(tap_out[NS-1]),
               64'(word[TOT-1-m]));
      end

      // R5 R6: random mix of modes
      for (int n = 0; n < 240; n++)
         step(1'($urandom), 1'($urandom), 3'($urandom), "R5");

      // R7: inputs flipped between edges leave stored taps unchanged
      for (int n = 0; n < 40; n++) begin
         logic [NS-1:0] held;
         logic we_new;
         held = tap_out;
         we_new = ~wr_en;
         wr_en = we_new; tap_in = 3'($urandom); ser_in = ~ser_in;
         #3ns;
         check(tap_out == held, "R7", 64'(tap_out), 64'(held));
         check(tap_oe == {NS{~we_new}}, "R6", 64'(tap_oe), 64'({NS{~we_new}}));
         step(1'($urandom), 1'($urandom), 3'($urandom), "R7");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule